// File: doc/BRIEF.md
# Seconds Real-Time Clock with Two Alarms

This block is a memory-mapped real-time clock. It keeps an unsigned 32-bit count of seconds that advances once for each pulse on a one-second tick input. The oscillator and the divider that produce this tick lie outside the block. Two alarm cells each compare the count against a programmable value. Each cell can also raise its flag periodically, either on every tick or on every `SLOW_DIV`-th tick. The flags are sticky and are cleared by writing 1 to them. Each alarm drives its own interrupt output, gated by that alarm's enable bit.

Software uses a simple strobe bus with a word address, write data, a write strobe, a read strobe and combinational read data. The internal commit of a write is slow. Every accepted write enters a small FIFO and then waits in a commit timer for `COMMIT_CYCLES` cycles before the target register changes. `busy_o` is high while any write is waiting or committing. After reset, the low byte of the test word reads non-zero. Software writes 0 to that word once it has set up the clock.

Top module: `secrtc_core`

## Requirements
- R1: After reset: the time, both alarm values, both configuration words, the calibration word and the status flags are 0. The test word reads `TEST_INIT` (default 0xA5, non-zero) in bits 7:0. `irq_o` and `busy_o` are 0.
- R2: Word index `bus_addr_i[4:2]` selects the register: 0 status, 1 alarm-0 config, 2 alarm-1 config, 3 time, 4 alarm-0 value, 5 alarm-1 value, 6 calibration, 7 test. Address bits 1:0 are ignored. Status reads its flags in bits 1:0, a config word reads bits 2:0 and the rest read 0, and the other registers read all 32 bits. `bus_rdata_o` is 0 while `bus_rd_i` is low.
- R3: A write sampled at a clock edge changes its register at the `COMMIT_CYCLES`+1-th following edge when the block is idle. Queued writes commit in order, `COMMIT_CYCLES`+1 edges apart. `busy_o` is high from the edge that samples a write until its commit edge.
- R4: A write sampled while `QDEPTH` writes already wait in the FIFO is discarded. The write inside the commit timer does not count toward `QDEPTH`.
- R5: Each edge with `tick_i` high adds 1 to the time, wrapping from 0xFFFFFFFF to 0.
- R6: When a time write commits on an edge with `tick_i` high, the written value is loaded and that tick neither increments the time nor matches an alarm.
- R7: Status bit i (bit 0 for alarm 0, bit 1 for alarm 1) is set on a tick edge that increments the time to a value equal to alarm value i. Loading the time by a write never sets it.
- R8: Committing a status write clears each flag whose data bit is 1 and leaves flags with a 0 data bit unchanged. If a flag is set and cleared on the same edge, the set wins.
- R9: Config bit 1 enables periodic setting of the flag and bit 2 selects its rate. With bit 2 set, every tick sets the flag. With bit 2 clear, only the tick that completes each group of `SLOW_DIV` ticks counted since reset sets it.
- R10: `irq_o[i]` is status flag i ANDed with bit 0 of config word i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second pulse, one cycle wide |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, combinational |
| busy_o | output | 1 | A write is queued or committing |
| irq_o | output | 2 | Alarm interrupts, one per alarm |

## Verification
The hardest situation to reach is a commit edge that coincides with a tick. Examples are a flag cleared on the very tick that sets it, or a time write that lands on a tick whose incremented value would match an alarm. The commit edge lies several cycles after the write strobe, so the bench holds `tick_i` high on every cycle across the whole commit window. That guarantees the coincidence without predicting the exact edge. A behavioural model with a write queue is compared on every clock, so any mistimed commit shows up in `busy_o`, `irq_o` or a readback.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned NUM_ALARMS = 2;
    localparam int unsigned CFG_W      = 3;

    // bit positions inside an alarm config word
    localparam int unsigned CFG_EN   = 0;
    localparam int unsigned CFG_PER  = 1;
    localparam int unsigned CFG_FAST = 2;

    typedef enum logic [2:0] {
        W_STATUS = 3'd0,
        W_CFG0   = 3'd1,
        W_CFG1   = 3'd2,
        W_TIME   = 3'd3,
        W_ALM0   = 3'd4,
        W_ALM1   = 3'd5,
        W_CALIB  = 3'd6,
        W_TEST   = 3'd7
    } widx_e;

    typedef struct packed {
        widx_e             idx;
        logic [DATA_W-1:0] data;
    } wreq_t;

endpackage

// File: rtl/secrtc_wrq.sv
module secrtc_wrq
    import secrtc_pkg::*;
#(
    parameter int unsigned DEPTH         = 4,
    parameter int unsigned COMMIT_CYCLES = 250
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  wreq_t req_i,
    output logic  commit_o,
    output wreq_t commit_req_o,
    output logic  busy_o
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned TW = $clog2(COMMIT_CYCLES + 1);

    typedef struct packed {
        wreq_t [DEPTH-1:0] mem;
        logic [PW-1:0]     rd_ptr;
        logic [PW-1:0]     wr_ptr;
        logic [CW-1:0]     count;
        wreq_t             slot;
        logic              slot_v;
        logic [TW-1:0]     cnt;
    } wq_t;

    wq_t  s_d, s_q;
    logic pop, push;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d      = s_q;
        commit_o = 1'b0;
        pop      = !s_q.slot_v && (s_q.count != '0);
        push     = wr_i && (s_q.count < CW'(DEPTH));
        if (s_q.slot_v) begin
            if (s_q.cnt == TW'(1)) begin
                commit_o   = 1'b1;
                s_d.slot_v = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (pop) begin
            s_d.slot   = s_q.mem[s_q.rd_ptr];
            s_d.slot_v = 1'b1;
            s_d.cnt    = TW'(COMMIT_CYCLES);
            s_d.rd_ptr = ptr_next(s_q.rd_ptr);
        end
        if (push) begin
            s_d.mem[s_q.wr_ptr] = req_i;
            s_d.wr_ptr          = ptr_next(s_q.wr_ptr);
        end
        s_d.count = s_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign commit_req_o = s_q.slot;
    assign busy_o       = s_q.slot_v || (s_q.count != '0);

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == CW'(DEPTH) && wr_i && s_q.slot_v) |=> s_q.count == CW'(DEPTH));
    p_commit_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/secrtc_alarm.sv
module secrtc_alarm
    import secrtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hit_i,
    input  logic             slow_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             clr_i,
    output logic             flag_o,
    output logic             irq_o
);
    logic flag_d, flag_q;
    logic per_set;

    always_comb begin
        per_set = tick_i && cfg_i[CFG_PER] && (cfg_i[CFG_FAST] || slow_i);
        flag_d  = hit_i || per_set || (flag_q && !clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q && cfg_i[CFG_EN];

    p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> flag_q);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    p_fast_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cfg_i[CFG_PER] && cfg_i[CFG_FAST]) |=> flag_q);

endmodule

// File: rtl/secrtc_core.sv
module secrtc_core
    import secrtc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 5,
    parameter int unsigned QDEPTH        = 4,
    parameter int unsigned COMMIT_CYCLES = 250,
    parameter int unsigned SLOW_DIV      = 60,
    parameter logic [7:0]  TEST_INIT     = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic                  busy_o,
    output logic [NUM_ALARMS-1:0] irq_o
);
    localparam int unsigned SW = $clog2(SLOW_DIV);

    typedef struct packed {
        logic [DATA_W-1:0]                 tm;
        logic [NUM_ALARMS-1:0][DATA_W-1:0] alm;
        logic [NUM_ALARMS-1:0][CFG_W-1:0]  cfg;
        logic [DATA_W-1:0]                 cal;
        logic [DATA_W-1:0]                 test;
        logic [SW-1:0]                     slow;
    } regs_t;

    regs_t r_d, r_q;

    logic                  addr_hi;
    widx_e                 aidx;
    wreq_t                 in_req, creq;
    logic                  commit;
    logic                  time_wr, tick_adv, slow_pulse;
    logic [DATA_W-1:0]     time_inc;
    logic [NUM_ALARMS-1:0] hit, clr, flag;
    logic                  unused_lowaddr;

    generate
        if (ADDR_W > 5) begin : g_hi
            assign addr_hi = |bus_addr_i[ADDR_W-1:5];
        end else begin : g_nohi
            assign addr_hi = 1'b0;
        end
    endgenerate

    assign unused_lowaddr = ^bus_addr_i[1:0];
    assign aidx           = widx_e'(bus_addr_i[4:2]);
    assign in_req         = '{idx: aidx, data: bus_wdata_i};

    secrtc_wrq #(.DEPTH(QDEPTH), .COMMIT_CYCLES(COMMIT_CYCLES)) u_wrq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (bus_wr_i && !addr_hi),
        .req_i        (in_req),
        .commit_o     (commit),
        .commit_req_o (creq),
        .busy_o       (busy_o)
    );

    always_comb begin
        time_wr    = commit && (creq.idx == W_TIME);
        tick_adv   = tick_i && !time_wr;
        time_inc   = r_q.tm + 1'b1;
        slow_pulse = tick_i && (r_q.slow == SW'(SLOW_DIV - 1));
        for (int i = 0; i < NUM_ALARMS; i++) begin
            hit[i] = tick_adv && (time_inc == r_q.alm[i]);
            clr[i] = commit && (creq.idx == W_STATUS) && creq.data[i];
        end
    end

    always_comb begin
        r_d = r_q;
        if (tick_i) r_d.slow = slow_pulse ? '0 : r_q.slow + 1'b1;
        if (tick_adv) r_d.tm = time_inc;
        if (commit) begin
            case (creq.idx)
                W_CFG0:  r_d.cfg[0] = creq.data[CFG_W-1:0];
                W_CFG1:  r_d.cfg[1] = creq.data[CFG_W-1:0];
                W_TIME:  r_d.tm     = creq.data;
                W_ALM0:  r_d.alm[0] = creq.data;
                W_ALM1:  r_d.alm[1] = creq.data;
                W_CALIB: r_d.cal    = creq.data;
                W_TEST:  r_d.test   = creq.data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.test <= {{(DATA_W-8){1'b0}}, TEST_INIT};
        end else begin
            r_q <= r_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
            secrtc_alarm u_alarm (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick_i (tick_i),
                .hit_i  (hit[g]),
                .slow_i (slow_pulse),
                .cfg_i  (r_q.cfg[g]),
                .clr_i  (clr[g]),
                .flag_o (flag[g]),
                .irq_o  (irq_o[g])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i && !addr_hi) begin
            case (aidx)
                W_STATUS: bus_rdata_o = DATA_W'(flag);
                W_CFG0:   bus_rdata_o = DATA_W'(r_q.cfg[0]);
                W_CFG1:   bus_rdata_o = DATA_W'(r_q.cfg[1]);
                W_TIME:   bus_rdata_o = r_q.tm;
                W_ALM0:   bus_rdata_o = r_q.alm[0];
                W_ALM1:   bus_rdata_o = r_q.alm[1];
                W_CALIB:  bus_rdata_o = r_q.cal;
                default:  bus_rdata_o = r_q.test;
            endcase
        end
    end

    p_tick_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !time_wr) |=> r_q.tm == $past(r_q.tm) + 32'd1);
    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> r_q.tm == $past(creq.data));
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !bus_wr_i) |=> $stable(r_q.cal) && $stable(r_q.alm));

endmodule

// File: tb/secrtc_core_bench.sv
module secrtc_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 3;
    localparam int QD         = 4;
    localparam int SDIV       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] rdata;
    logic        busy;
    logic [1:0]  irq;

    secrtc_core #(.ADDR_W(5), .QDEPTH(QD), .COMMIT_CYCLES(CYC), .SLOW_DIV(SDIV),
                  .TEST_INIT(8'hA5)) u_secrtc_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_rdata_o(rdata), .busy_o(busy), .irq_o(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    typedef struct { int idx; logic [31:0] data; } bw_t;
    bw_t         m_q[$];
    bw_t         m_slot;
    bit          m_sv;
    int          m_cnt, m_slow;
    logic [31:0] m_time, m_cal, m_test;
    logic [31:0] m_alm [2];
    logic [2:0]  m_cfg [2];
    logic [1:0]  m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_sv = 0; m_cnt = 0; m_slow = 0;
            m_time = 0; m_cal = 0; m_test = 32'hA5; m_flag = 0;
            m_alm[0] = 0; m_alm[1] = 0; m_cfg[0] = 0; m_cfg[1] = 0;
        end else begin
            automatic bit cm = m_sv && (m_cnt == 1);
            automatic int pre = m_q.size();
            automatic bit twr = cm && (m_slot.idx == 3);
            automatic logic [31:0] ninc = m_time + 32'd1;
            automatic bit slowp = tick && (m_slow == SDIV - 1);
            automatic logic [1:0] set = '0, clrb = '0;
            for (int i = 0; i < 2; i++) begin
                set[i] = (tick && !twr && ninc == m_alm[i]) ||
                         (tick && m_cfg[i][1] && (m_cfg[i][2] || slowp));
                clrb[i] = cm && (m_slot.idx == 0) && m_slot.data[i];
            end
            if (tick) m_slow = slowp ? 0 : m_slow + 1;
            if (tick && !twr) m_time = ninc;
            if (cm) begin
                case (m_slot.idx)
                    1: m_cfg[0] = m_slot.data[2:0];
                    2: m_cfg[1] = m_slot.data[2:0];
                    3: m_time = m_slot.data;
                    4: m_alm[0] = m_slot.data;
                    5: m_alm[1] = m_slot.data;
                    6: m_cal = m_slot.data;
                    7: m_test = m_slot.data;
                    default: ;
                endcase
            end
            m_flag = set | (m_flag & ~clrb);
            if (cm) m_sv = 0;
            else if (m_sv) m_cnt--;
            else if (pre > 0) begin m_slot = m_q.pop_front(); m_sv = 1; m_cnt = CYC; end
            if (wr && pre < QD) m_q.push_back('{idx: int'(addr[4:2]), data: wdata});
        end
    end

    function automatic logic [31:0] mread(input int idx);
        case (idx)
            0: return {30'b0, m_flag};
            1: return {29'b0, m_cfg[0]};
            2: return {29'b0, m_cfg[1]};
            3: return m_time;
            4: return m_alm[0];
            5: return m_alm[1];
            6: return m_cal;
            default: return m_test;
        endcase
    endfunction

    // ---------------- checking ----------------
    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 irq", {30'b0, irq},
                {30'b0, m_flag[1] & m_cfg[1][0], m_flag[0] & m_cfg[0][0]});
            chk("R3 busy", {31'b0, busy}, {31'b0, (m_sv || m_q.size() > 0)});
        end
    end

    task automatic rreg(input int idx, input string tag, input logic [1:0] lo = 2'b00);
        @(negedge clk);
        rd = 1'b1; addr = {idx[2:0], lo};
        #1 chk(tag, rdata, mread(idx));
        rd = 1'b0;
    endtask

    task automatic wreg(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = {idx[2:0], 2'b00}; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        for (int i = 0; i < 8; i++) rreg(i, "R1 reset value");
        @(negedge clk); rd = 1'b1; addr = 5'h1C;
        #1 chk("R1 test low byte non-zero", {31'b0, rdata[7:0] != 8'h00}, 32'd1);
        chk("R1 idle after reset", {30'b0, irq, busy}, 32'd0);
        rd = 1'b0;
        // R2 read strobe low gives zero; low address bits ignored
        #1 chk("R2 rdata without strobe", rdata, 32'd0);
        rreg(7, "R2 low addr bits ignored", 2'b11);

        // R3 commit latency
        wreg(1, 32'hFFFF_FFF9);
        rreg(1, "R3 old value before commit");
        chk("R3 busy during commit", {31'b0, busy}, 32'd1);
        wait_idle();
        rreg(1, "R2 config readback masked");

        wreg(3, 32'd100); wreg(4, 32'd103); wreg(7, 32'd0);
        wait_idle();
        rreg(7, "R2 test cleared"); rreg(3, "R2 time readback");

        // R7 alarm match
        ticks(2); rreg(0, "R7 no flag before match");
        ticks(1); rreg(0, "R7 flag at match"); rreg(3, "R5 time advanced");
        @(negedge clk); chk("R10 irq on enabled alarm", {31'b0, irq[0]}, 32'd1);

        // R8 write-one-to-clear
        wreg(0, 32'd2); wait_idle(); rreg(0, "R8 zero bit leaves flag");
        wreg(0, 32'd1); wait_idle(); rreg(0, "R8 one bit clears flag");

        // R9 fast periodic, and set beats clear
        wreg(1, 32'd6); wait_idle();
        ticks(1); rreg(0, "R9 fast periodic sets flag");
        @(negedge clk); tick = 1'b1;
        wreg(0, 32'd1);
        repeat (CYC + 3) @(negedge clk);
        tick = 1'b0;
        rreg(0, "R8 set wins over clear");
        wreg(1, 32'd0); wreg(0, 32'd3); wait_idle();
        rreg(0, "R8 both flags cleared");

        // R9 slow periodic on alarm 1
        wreg(2, 32'd2); wait_idle();
        for (int k = 0; k < 6; k++) begin
            ticks(1); rreg(0, "R9 slow periodic");
        end
        wreg(2, 32'd0); wreg(0, 32'd3); wait_idle();

        // R6 time write during continuous ticks
        @(negedge clk); tick = 1'b1;
        wreg(3, 32'd500);
        repeat (CYC + 3) @(negedge clk);
        tick = 1'b0;
        rreg(3, "R6 written time wins over tick");
        wreg(4, 32'd600); wait_idle();
        @(negedge clk); tick = 1'b1;
        wreg(3, 32'd600);
        repeat (CYC + 3) @(negedge clk);
        tick = 1'b0;
        rreg(0, "R6 loaded time sets no flag"); rreg(3, "R6 time after load");

        // R5 wrap and R7 match at zero
        wreg(3, 32'hFFFF_FFFF); wreg(5, 32'd0); wreg(2, 32'd1); wait_idle();
        ticks(1);
        rreg(3, "R5 wrap to zero"); rreg(0, "R7 alarm 1 matches at zero");
        @(negedge clk); chk("R10 irq alarm 1", {31'b0, irq[1]}, 32'd1);

        // R4 queue overflow
        wait_idle();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            wr = 1'b1; addr = 5'h18; wdata = 32'hC0DE_0000 + k;
        end
        @(negedge clk); wr = 1'b0;
        wait_idle();
        rreg(6, "R4 extra write dropped");
        chk("R4 last kept value", rdata, 32'hC0DE_0004);
        rreg(4, "R2 alarm 0 readback");
        summary();
    end
endmodule